// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block is the issue stage of a SIMT core. Every cycle it looks at the head of each warp's instruction buffer and moves ready instructions into three single-entry execution latches. The SP latch takes simple ALU work. The SFU latch takes special-function work. The MEM latch takes loads, stores and memory barriers. The scoreboard, the reconvergence stack and the execution units are outside the block: their state arrives as per-warp flags, PCs and latch-empty inputs. In return the block drives issue strobes, per-warp flush-and-redirect commands, and buffer step counts.

The warps are split among `NUM_SCHED` scheduler units. Warp `w` belongs to unit `w % NUM_SCHED`, at list position `w / NUM_SCHED`, and `NUM_WARPS` must be a multiple of `NUM_SCHED`. Each unit searches its own list in round-robin order. It stops at the first warp that issues anything, and that warp may issue up to two instructions in the same cycle. The units are evaluated in index order. A latch that a lower-numbered unit fills in a cycle looks full to the units after it.

Each warp presents its two head buffer slots. A slot carries an occupied bit, a valid bit, a PC and a 2-bit class. The class codes are 0 = ALU (SP only), 1 = SFU only, 2 = either unit, 3 = memory.

Top module: `rr_warp_issue`

## Requirements
- R1: Each unit keeps a pointer to a position in its own warp list, and that pointer resets to 0. The search begins at pointer+1 and wraps through the list, so right after reset unit 0 looks at list position 1 (warp `NUM_SCHED`) first.
- R2: When a warp issues, the pointer becomes that warp's list position on the next clock edge. In a cycle with no issue the pointer keeps its value.
- R3: Warp `w` is handled by unit `w % NUM_SCHED`. A latch that one unit fills in a cycle is treated as full by every higher-numbered unit in that same cycle.
- R4: A warp whose wait flag is set, or whose two head slots are both unoccupied, is not examined. It gets no issue, no flush and a step count of 0.
- R5: An occupied slot whose PC differs from the warp's stack-top PC is a control hazard. The block raises that warp's flush bit, drives its redirect PC with the stack-top PC, issues nothing from that slot, and examines no further slot of the warp.
- R6: A slot that is marked valid but is unoccupied causes the same flush and redirect as R5.
- R7: While the warp's scoreboard collision flag is set, none of its instructions issues.
- R8: A memory-class instruction issues only to the MEM latch, and only when that latch is empty.
- R9: A class 0 or class 2 instruction goes to the SP latch when SP is free. If SP is busy, a class 1 or class 2 instruction goes to SFU when SFU is free. Any other case stalls.
- R10: After slot 0, slot 1 is also examined, provided slot 0 did not flush and the buffer is still non-empty (slot 0 stalled, or slot 1 is occupied). Each latch takes at most one instruction per cycle. The `*_slot` outputs name the slot that issued.
- R11: The 2-bit step count of each examined warp equals the number of slots examined for it (1 or 2), whether or not they issued.
- R12: The search stops at the first warp that issues. Warps examined before it may still flush and step. Warps after it in search order are untouched (step 0, no flush).
- R13: Each unit reports three status flags. `st_valid` means a matching-PC instruction was seen. `st_ready` means such an instruction had no collision. `st_issued` means something issued. All three cover only the warps the unit examined that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_wait | input | NUM_WARPS | Per-warp wait flag |
| s0_occ | input | NUM_WARPS | Slot 0 holds an instruction |
| s0_vld | input | NUM_WARPS | Slot 0 valid bit |
| s0_pc | input | NUM_WARPS*PC_W | Slot 0 PC |
| s0_op | input | 2*NUM_WARPS | Slot 0 class |
| s1_occ | input | NUM_WARPS | Slot 1 holds an instruction |
| s1_vld | input | NUM_WARPS | Slot 1 valid bit |
| s1_pc | input | NUM_WARPS*PC_W | Slot 1 PC |
| s1_op | input | 2*NUM_WARPS | Slot 1 class |
| stk_pc | input | NUM_WARPS*PC_W | Reconvergence-stack top PC per warp |
| sb_hit | input | NUM_WARPS | Scoreboard collision per warp |
| sp_empty | input | 1 | SP latch empty |
| sfu_empty | input | 1 | SFU latch empty |
| mem_empty | input | 1 | MEM latch empty |
| sp_go | output | 1 | Write SP latch |
| sp_wid | output | WID_W | Warp written to SP |
| sp_slot | output | 1 | Slot written to SP |
| sfu_go | output | 1 | Write SFU latch |
| sfu_wid | output | WID_W | Warp written to SFU |
| sfu_slot | output | 1 | Slot written to SFU |
| mem_go | output | 1 | Write MEM latch |
| mem_wid | output | WID_W | Warp written to MEM |
| mem_slot | output | 1 | Slot written to MEM |
| flush | output | NUM_WARPS | Flush buffer and redirect, per warp |
| redir_pc | output | NUM_WARPS*PC_W | Redirect PC (stack top when flushing, else 0) |
| step_cnt | output | 2*NUM_WARPS | Slots stepped per warp |
| st_valid | output | NUM_SCHED | Valid instruction seen, per unit |
| st_ready | output | NUM_SCHED | Ready instruction seen, per unit |
| st_issued | output | NUM_SCHED | Issue made, per unit |

## Verification
Two functions can land in the same cycle and are exercised together. The first pair is a slot-0 stall and a slot-1 action in the same warp: a second issue, a redirect flush, or a stall caused by the lane slot 0 just took. These are provoked with table rows that combine a busy or taken latch with a second instruction, and each row is judged on the issue strobes, slot numbers, flush bit and step count. The second pair is two units contending for the SP latch. The bench readies one warp in each unit at once and checks two things: the second unit moves to SFU for an either-unit instruction, and it stalls with a step count of 2 for an SP-only one.

// File: rtl/rris_pkg.sv
package rris_pkg;

    typedef enum logic [1:0] {
        OPC_ALU  = 2'd0,
        OPC_SFU  = 2'd1,
        OPC_DUAL = 2'd2,
        OPC_MEM  = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_SP   = 2'd1,
        DST_SFU  = 2'd2,
        DST_MEM  = 2'd3
    } dst_e;

    typedef struct packed {
        logic sp;
        logic sfu;
        logic mem;
    } lanes_t;

    typedef struct packed {
        logic flush;
        logic seen;
        logic ready;
        dst_e dst;
    } sres_t;

    typedef struct packed {
        logic       flush;
        logic [1:0] steps;
        dst_e       dst0;
        dst_e       dst1;
        logic       saw_valid;
        logic       saw_ready;
    } wres_t;

    function automatic dst_e route_op(opc_e op, lanes_t fr);
        dst_e d = DST_NONE;
        if (op == OPC_MEM) begin
            if (fr.mem) d = DST_MEM;
        end else if (fr.sp && op != OPC_SFU) begin
            d = DST_SP;
        end else if (op != OPC_ALU && fr.sfu) begin
            d = DST_SFU;
        end
        return d;
    endfunction

    function automatic lanes_t take_lane(lanes_t fr, dst_e d);
        lanes_t r = fr;
        case (d)
            DST_SP:  r.sp  = 1'b0;
            DST_SFU: r.sfu = 1'b0;
            DST_MEM: r.mem = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    function automatic sres_t eval_slot(logic occ, logic vld, logic pc_ok,
                                        opc_e op, logic collide, lanes_t fr);
        sres_t r = '0;
        if (!occ) begin
            r.flush = vld;
        end else if (!pc_ok) begin
            r.flush = 1'b1;
        end else begin
            r.seen = 1'b1;
            if (!collide) begin
                r.ready = 1'b1;
                r.dst   = route_op(op, fr);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rris_warp_eval.sv
module rris_warp_eval
    import rris_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              waiting,
    input  logic [1:0]        occ,
    input  logic [1:0]        vld,
    input  logic [2*PC_W-1:0] pc,
    input  opc_e              op0,
    input  opc_e              op1,
    input  logic [PC_W-1:0]   top_pc,
    input  logic              collide,
    input  lanes_t            free_in,
    output wres_t             res
);

    logic [1:0] pc_ok;
    sres_t      s0, s1;
    lanes_t     fr1;
    logic       look0, look1;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            pc_ok[i] = (pc[i*PC_W +: PC_W] == top_pc);
        end
        look0 = !waiting && (occ[0] || occ[1]);
        s0    = eval_slot(occ[0], vld[0], pc_ok[0], op0, collide, free_in);
        fr1   = take_lane(free_in, s0.dst);
        // second slot only if no flush and the buffer still holds something
        look1 = look0 && !s0.flush && ((occ[0] && s0.dst == DST_NONE) || occ[1]);
        s1    = eval_slot(occ[1], vld[1], pc_ok[1], op1, collide, fr1);
        res   = '0;
        if (look0) begin
            res.steps     = look1 ? 2'd2 : 2'd1;
            res.flush     = s0.flush || (look1 && s1.flush);
            res.dst0      = s0.dst;
            res.dst1      = look1 ? s1.dst : DST_NONE;
            res.saw_valid = s0.seen || (look1 && s1.seen);
            res.saw_ready = s0.ready || (look1 && s1.ready);
        end
    end

endmodule

// File: rtl/rris_sched_unit.sv
module rris_sched_unit
    import rris_pkg::*;
#(
    parameter  int LIST  = 8,
    parameter  int PC_W  = 16,
    localparam int IDX_W = (LIST > 1) ? $clog2(LIST) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LIST-1:0]      waiting,
    input  logic [LIST-1:0]      occ0,
    input  logic [LIST-1:0]      occ1,
    input  logic [LIST-1:0]      vld0,
    input  logic [LIST-1:0]      vld1,
    input  logic [LIST-1:0]      collide,
    input  logic [LIST*PC_W-1:0] pc0,
    input  logic [LIST*PC_W-1:0] pc1,
    input  logic [LIST*PC_W-1:0] top_pc,
    input  logic [2*LIST-1:0]    op0,
    input  logic [2*LIST-1:0]    op1,
    input  lanes_t               free_in,
    output lanes_t               free_out,
    output logic                 win_hit,
    output logic [IDX_W-1:0]     win_idx,
    output dst_e                 win_dst0,
    output dst_e                 win_dst1,
    output logic [LIST-1:0]      flush,
    output logic [2*LIST-1:0]    steps,
    output logic                 st_valid,
    output logic                 st_ready,
    output logic                 st_issued
);

    wres_t            res [LIST];
    logic [IDX_W-1:0] last_q;

    for (genvar g = 0; g < LIST; g++) begin : g_warp
        rris_warp_eval #(.PC_W(PC_W)) u_eval (
            .waiting (waiting[g]),
            .occ     ({occ1[g], occ0[g]}),
            .vld     ({vld1[g], vld0[g]}),
            .pc      ({pc1[g*PC_W +: PC_W], pc0[g*PC_W +: PC_W]}),
            .op0     (opc_e'(op0[2*g +: 2])),
            .op1     (opc_e'(op1[2*g +: 2])),
            .top_pc  (top_pc[g*PC_W +: PC_W]),
            .collide (collide[g]),
            .free_in (free_in),
            .res     (res[g])
        );

        // R4
        wait_idle_chk: assert property (@(posedge clk) disable iff (rst)
            waiting[g] |-> (steps[2*g +: 2] == 2'd0 && !flush[g]));
    end

    always_comb begin
        logic             hit;
        logic [IDX_W-1:0] wi;
        int               idx;
        hit      = 1'b0;
        wi       = '0;
        flush    = '0;
        steps    = '0;
        st_valid = 1'b0;
        st_ready = 1'b0;
        for (int k = 0; k < LIST; k++) begin
            idx = (int'(last_q) + 1 + k) % LIST;
            if (!hit) begin
                flush[idx]         = res[idx].flush;
                steps[2*idx +: 2]  = res[idx].steps;
                st_valid           = st_valid | res[idx].saw_valid;
                st_ready           = st_ready | res[idx].saw_ready;
                if (res[idx].dst0 != DST_NONE || res[idx].dst1 != DST_NONE) begin
                    hit = 1'b1;
                    wi  = IDX_W'(idx);
                end
            end
        end
        win_hit   = hit;
        win_idx   = wi;
        win_dst0  = hit ? res[wi].dst0 : DST_NONE;
        win_dst1  = hit ? res[wi].dst1 : DST_NONE;
        free_out  = take_lane(take_lane(free_in, win_dst0), win_dst1);
        st_issued = hit;
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= '0;
        else if (win_hit) last_q <= win_idx;
    end

    // R2
    ptr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        win_hit |=> (last_q == $past(win_idx)));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win_hit |=> $stable(last_q));

    // R10
    dual_lane_chk: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (win_dst0 == DST_NONE || win_dst0 != win_dst1));

endmodule

// File: rtl/rr_warp_issue.sv
module rr_warp_issue
    import rris_pkg::*;
#(
    parameter  int NUM_WARPS = 8,
    parameter  int NUM_SCHED = 1,
    parameter  int PC_W      = 16,
    localparam int LIST      = NUM_WARPS / NUM_SCHED,
    localparam int IDX_W     = (LIST > 1) ? $clog2(LIST) : 1,
    localparam int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_WARPS-1:0]      warp_wait,
    input  logic [NUM_WARPS-1:0]      s0_occ,
    input  logic [NUM_WARPS-1:0]      s0_vld,
    input  logic [NUM_WARPS*PC_W-1:0] s0_pc,
    input  logic [2*NUM_WARPS-1:0]    s0_op,
    input  logic [NUM_WARPS-1:0]      s1_occ,
    input  logic [NUM_WARPS-1:0]      s1_vld,
    input  logic [NUM_WARPS*PC_W-1:0] s1_pc,
    input  logic [2*NUM_WARPS-1:0]    s1_op,
    input  logic [NUM_WARPS*PC_W-1:0] stk_pc,
    input  logic [NUM_WARPS-1:0]      sb_hit,
    input  logic                      sp_empty,
    input  logic                      sfu_empty,
    input  logic                      mem_empty,
    output logic                      sp_go,
    output logic [WID_W-1:0]          sp_wid,
    output logic                      sp_slot,
    output logic                      sfu_go,
    output logic [WID_W-1:0]          sfu_wid,
    output logic                      sfu_slot,
    output logic                      mem_go,
    output logic [WID_W-1:0]          mem_wid,
    output logic                      mem_slot,
    output logic [NUM_WARPS-1:0]      flush,
    output logic [NUM_WARPS*PC_W-1:0] redir_pc,
    output logic [2*NUM_WARPS-1:0]    step_cnt,
    output logic [NUM_SCHED-1:0]      st_valid,
    output logic [NUM_SCHED-1:0]      st_ready,
    output logic [NUM_SCHED-1:0]      st_issued
);

    lanes_t           chain  [NUM_SCHED+1];
    logic [IDX_W-1:0] widx_s [NUM_SCHED];
    dst_e             d0_s   [NUM_SCHED];
    dst_e             d1_s   [NUM_SCHED];
    logic [NUM_SCHED-1:0] hit_s;

    assign chain[0] = {sp_empty, sfu_empty, mem_empty};

    for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sched
        logic [LIST-1:0]      l_wait, l_occ0, l_occ1, l_vld0, l_vld1, l_coll, l_flush;
        logic [LIST*PC_W-1:0] l_pc0, l_pc1, l_top;
        logic [2*LIST-1:0]    l_op0, l_op1, l_steps;

        for (genvar j = 0; j < LIST; j++) begin : g_map
            localparam int W = j * NUM_SCHED + s;
            assign l_wait[j]                 = warp_wait[W];
            assign l_occ0[j]                 = s0_occ[W];
            assign l_occ1[j]                 = s1_occ[W];
            assign l_vld0[j]                 = s0_vld[W];
            assign l_vld1[j]                 = s1_vld[W];
            assign l_coll[j]                 = sb_hit[W];
            assign l_pc0[j*PC_W +: PC_W]     = s0_pc[W*PC_W +: PC_W];
            assign l_pc1[j*PC_W +: PC_W]     = s1_pc[W*PC_W +: PC_W];
            assign l_top[j*PC_W +: PC_W]     = stk_pc[W*PC_W +: PC_W];
            assign l_op0[2*j +: 2]           = s0_op[2*W +: 2];
            assign l_op1[2*j +: 2]           = s1_op[2*W +: 2];
            assign flush[W]                  = l_flush[j];
            assign step_cnt[2*W +: 2]        = l_steps[2*j +: 2];
        end

        rris_sched_unit #(.LIST(LIST), .PC_W(PC_W)) u_sched (
            .clk       (clk),
            .rst       (rst),
            .waiting   (l_wait),
            .occ0      (l_occ0),
            .occ1      (l_occ1),
            .vld0      (l_vld0),
            .vld1      (l_vld1),
            .collide   (l_coll),
            .pc0       (l_pc0),
            .pc1       (l_pc1),
            .top_pc    (l_top),
            .op0       (l_op0),
            .op1       (l_op1),
            .free_in   (chain[s]),
            .free_out  (chain[s+1]),
            .win_hit   (hit_s[s]),
            .win_idx   (widx_s[s]),
            .win_dst0  (d0_s[s]),
            .win_dst1  (d1_s[s]),
            .flush     (l_flush),
            .steps     (l_steps),
            .st_valid  (st_valid[s]),
            .st_ready  (st_ready[s]),
            .st_issued (st_issued[s])
        );
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_redir
        assign redir_pc[w*PC_W +: PC_W] = flush[w] ? stk_pc[w*PC_W +: PC_W] : '0;
    end

    always_comb begin
        int   w;
        dst_e d;
        sp_go  = 1'b0; sp_wid  = '0; sp_slot  = 1'b0;
        sfu_go = 1'b0; sfu_wid = '0; sfu_slot = 1'b0;
        mem_go = 1'b0; mem_wid = '0; mem_slot = 1'b0;
        for (int s = 0; s < NUM_SCHED; s++) begin
            w = int'(widx_s[s]) * NUM_SCHED + s;
            for (int t = 0; t < 2; t++) begin
                d = (t == 0) ? d0_s[s] : d1_s[s];
                if (hit_s[s]) begin
                    case (d)
                        DST_SP:  begin sp_go  = 1'b1; sp_wid  = WID_W'(w); sp_slot  = t[0]; end
                        DST_SFU: begin sfu_go = 1'b1; sfu_wid = WID_W'(w); sfu_slot = t[0]; end
                        DST_MEM: begin mem_go = 1'b1; mem_wid = WID_W'(w); mem_slot = t[0]; end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8
    mem_lane_chk: assert property (@(posedge clk) disable iff (rst)
        mem_go |-> mem_empty);

    // R9
    sp_lane_chk: assert property (@(posedge clk) disable iff (rst)
        sp_go |-> sp_empty);

    // R9
    sfu_lane_chk: assert property (@(posedge clk) disable iff (rst)
        sfu_go |-> sfu_empty);

    // R13
    issued_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_go || sfu_go || mem_go) == (|st_issued));

endmodule

// File: tb/test_rr_warp_issue.sv
`timescale 1ns/1ps
module test_rr_warp_issue;

    localparam int NW = 8;
    localparam int NS = 2;
    localparam int PW = 16;
    localparam int WW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0]    warp_wait, s0_occ, s0_vld, s1_occ, s1_vld, sb_hit;
    logic [NW*PW-1:0] s0_pc, s1_pc, stk_pc;
    logic [2*NW-1:0]  s0_op, s1_op;
    logic sp_empty, sfu_empty, mem_empty;
    logic sp_go, sp_slot, sfu_go, sfu_slot, mem_go, mem_slot;
    logic [WW-1:0] sp_wid, sfu_wid, mem_wid;
    logic [NW-1:0] flush;
    logic [NW*PW-1:0] redir_pc;
    logic [2*NW-1:0] step_cnt;
    logic [NS-1:0] st_valid, st_ready, st_issued;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rr_warp_issue #(.NUM_WARPS(NW), .NUM_SCHED(NS), .PC_W(PW)) i_rr_warp_issue (
        .clk(clk), .rst(rst), .warp_wait(warp_wait),
        .s0_occ(s0_occ), .s0_vld(s0_vld), .s0_pc(s0_pc), .s0_op(s0_op),
        .s1_occ(s1_occ), .s1_vld(s1_vld), .s1_pc(s1_pc), .s1_op(s1_op),
        .stk_pc(stk_pc), .sb_hit(sb_hit),
        .sp_empty(sp_empty), .sfu_empty(sfu_empty), .mem_empty(mem_empty),
        .sp_go(sp_go), .sp_wid(sp_wid), .sp_slot(sp_slot),
        .sfu_go(sfu_go), .sfu_wid(sfu_wid), .sfu_slot(sfu_slot),
        .mem_go(mem_go), .mem_wid(mem_wid), .mem_slot(mem_slot),
        .flush(flush), .redir_pc(redir_pc), .step_cnt(step_cnt),
        .st_valid(st_valid), .st_ready(st_ready), .st_issued(st_issued)
    );

    // inputs {o0 v0 h0 op0[2] o1 v1 h1 op1[2] coll spE sfuE memE}
    // expect {spGo spSlot sfuGo sfuSlot memGo memSlot flush step[2]}
    localparam logic [22:0] TBL [19] = '{
        {14'b1_1_0_00_0_0_0_00_0_111, 9'b1_0_0_0_0_0_0_01}, // R9 ALU to SP
        {14'b1_1_0_01_0_0_0_00_0_111, 9'b0_0_1_0_0_0_0_01}, // R9 SFU op
        {14'b1_1_0_10_0_0_0_00_0_111, 9'b1_0_0_0_0_0_0_01}, // R9 either-unit prefers SP
        {14'b1_1_0_10_0_0_0_00_0_011, 9'b0_0_1_0_0_0_0_01}, // R9 either-unit falls to SFU
        {14'b1_1_0_00_0_0_0_00_0_011, 9'b0_0_0_0_0_0_0_10}, // R9 R11 ALU stalls, two steps
        {14'b1_1_0_11_0_0_0_00_0_111, 9'b0_0_0_0_1_0_0_01}, // R8 memory
        {14'b1_1_0_11_0_0_0_00_0_110, 9'b0_0_0_0_0_0_0_10}, // R8 MEM busy
        {14'b1_1_0_00_0_0_0_00_1_111, 9'b0_0_0_0_0_0_0_10}, // R7 collision
        {14'b1_1_1_00_0_0_0_00_0_111, 9'b0_0_0_0_0_0_1_01}, // R5 hazard
        {14'b0_1_0_00_1_1_0_00_0_111, 9'b0_0_0_0_0_0_1_01}, // R6 valid without instruction
        {14'b1_1_0_00_1_1_0_01_0_111, 9'b1_0_1_1_0_0_0_10}, // R10 dual issue
        {14'b1_1_0_00_1_1_0_00_0_111, 9'b1_0_0_0_0_0_0_10}, // R10 SP already taken
        {14'b1_1_0_10_1_1_0_10_0_111, 9'b1_0_1_1_0_0_0_10}, // R10 either-unit pair
        {14'b1_1_0_11_1_1_0_00_0_111, 9'b1_1_0_0_1_0_0_10}, // R10 MEM plus ALU
        {14'b1_1_0_00_1_1_1_00_0_011, 9'b0_0_0_0_0_0_1_10}, // R5 R10 stall then hazard
        {14'b1_1_0_01_0_0_0_00_0_101, 9'b0_0_0_0_0_0_0_10}, // R9 SFU-only never to SP
        {14'b1_1_0_00_1_1_0_11_0_110, 9'b1_0_0_0_0_0_0_10}, // R10 second stalls on MEM
        {14'b0_0_0_00_1_1_0_00_0_111, 9'b1_1_0_0_0_0_0_10}, // R11 empty head slot stepped
        {14'b1_1_1_00_1_1_0_00_0_111, 9'b0_0_0_0_0_0_1_01}  // R5 stop after flush
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [PW-1:0] base_pc(input int w);
        return 16'h0100 + 16'h0040 * w[15:0];
    endfunction

    task automatic clear_in();
        warp_wait = '0; s0_occ = '0; s0_vld = '0; s1_occ = '0; s1_vld = '0; sb_hit = '0;
        s0_op = '0; s1_op = '0;
        for (int w = 0; w < NW; w++) begin
            stk_pc[w*PW +: PW] = base_pc(w);
            s0_pc[w*PW +: PW]  = base_pc(w);
            s1_pc[w*PW +: PW]  = base_pc(w);
        end
        sp_empty = 1'b1; sfu_empty = 1'b1; mem_empty = 1'b1;
    endtask

    task automatic put(input int w, input int s, input logic occ, input logic vld,
                       input logic hz, input logic [1:0] op);
        if (s == 0) begin
            s0_occ[w] = occ; s0_vld[w] = vld; s0_op[2*w +: 2] = op;
            s0_pc[w*PW +: PW] = base_pc(w) + (hz ? 16'd4 : 16'd0);
        end else begin
            s1_occ[w] = occ; s1_vld[w] = vld; s1_op[2*w +: 2] = op;
            s1_pc[w*PW +: PW] = base_pc(w) + (hz ? 16'd4 : 16'd0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_in();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [13:0] vin;
        logic [8:0]  vexp;
        do_reset();

        // R4 reset state: no instructions, nothing moves
        #1;
        check("R4 idle after reset",
              {sp_go, sfu_go, mem_go, flush, step_cnt, st_issued, st_valid},
              '0);

        // table walk, warp 0 only
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            clear_in();
            {vin, vexp} = TBL[i];
            put(0, 0, vin[13], vin[12], vin[11], vin[10:9]);
            put(0, 1, vin[8], vin[7], vin[6], vin[5:4]);
            sb_hit[0] = vin[3];
            {sp_empty, sfu_empty, mem_empty} = vin[2:0];
            #1;
            check($sformatf("table row %0d routing", i),
                  {sp_go, sp_go & sp_slot, sfu_go, sfu_go & sfu_slot,
                   mem_go, mem_go & mem_slot, flush[0], step_cnt[1:0]},
                  {55'd0, vexp});
            check($sformatf("R3 R5 table row %0d warp id and redirect", i),
                  {(sp_go && sp_wid != 0) || (sfu_go && sfu_wid != 0) || (mem_go && mem_wid != 0),
                   flush[0] && (redir_pc[PW-1:0] != base_pc(0))},
                  '0);
        end

        // R1 R2 round-robin over unit 0 (warps 0,2,4,6 at list positions 0..3)
        do_reset();
        put(0, 0, 1, 1, 0, 2'd0); put(2, 0, 1, 1, 0, 2'd0); put(4, 0, 1, 1, 0, 2'd0);
        #1; check("R1 first pick after reset", {sp_go, 5'(sp_wid)}, {1'b1, 5'd2});
        @(negedge clk); #1; check("R2 next pick", {sp_go, 5'(sp_wid)}, {1'b1, 5'd4});
        @(negedge clk); #1; check("R1 wrap skips empty warp 6", {sp_go, 5'(sp_wid)}, {1'b1, 5'd0});
        @(negedge clk); #1; check("R1 back to warp 2", {sp_go, 5'(sp_wid)}, {1'b1, 5'd2});

        // R2 pointer holds without issue
        do_reset();
        put(0, 0, 1, 1, 0, 2'd0); put(2, 0, 1, 1, 0, 2'd0); put(4, 0, 1, 1, 0, 2'd0);
        sp_empty = 1'b0;
        #1; check("R2 no issue while SP busy", {sp_go, sfu_go, mem_go}, 3'b000);
        @(negedge clk); sp_empty = 1'b1;
        #1; check("R2 pointer unchanged", {sp_go, 5'(sp_wid)}, {1'b1, 5'd2});

        // R12 stop at first issuer
        do_reset();
        put(2, 0, 1, 1, 0, 2'd0); sb_hit[2] = 1'b1;
        put(4, 0, 1, 1, 0, 2'd0); put(6, 0, 1, 1, 0, 2'd0);
        #1; check("R12 stalled warp stepped, later warp untouched",
                  {sp_go, 5'(sp_wid), step_cnt[5:4], step_cnt[9:8], step_cnt[13:12]},
                  {1'b1, 5'd4, 2'd2, 2'd1, 2'd0});

        // R3 unit chaining on a shared latch
        do_reset();
        put(2, 0, 1, 1, 0, 2'd0); put(1, 0, 1, 1, 0, 2'd2);
        #1; check("R3 second unit moves to SFU",
                  {sp_go, 5'(sp_wid), sfu_go, 5'(sfu_wid)}, {1'b1, 5'd2, 1'b1, 5'd1});
        @(negedge clk); put(1, 0, 1, 1, 0, 2'd0);
        #1; check("R3 second unit stalls on taken SP",
                  {sp_go, 5'(sp_wid), sfu_go, step_cnt[3:2]}, {1'b1, 5'd2, 1'b0, 2'd2});

        // R4 waiting warp with a hazard is ignored
        do_reset();
        put(0, 0, 1, 1, 1, 2'd0); warp_wait[0] = 1'b1;
        #1; check("R4 waiting warp untouched", {sp_go, flush[0], step_cnt[1:0]}, 4'd0);

        // R13 status flags of unit 0
        do_reset();
        put(0, 0, 1, 1, 0, 2'd0); sb_hit[0] = 1'b1;
        #1; check("R13 collision flags", {st_valid[0], st_ready[0], st_issued[0]}, 3'b100);
        @(negedge clk); sb_hit[0] = 1'b0; sp_empty = 1'b0;
        #1; check("R13 ready but stalled flags", {st_valid[0], st_ready[0], st_issued[0]}, 3'b110);
        @(negedge clk); sp_empty = 1'b1;
        #1; check("R13 issued flags", {st_valid[0], st_ready[0], st_issued[0]}, 3'b111);
        @(negedge clk); put(0, 0, 1, 1, 1, 2'd0);
        #1; check("R13 hazard flags", {st_valid[0], st_ready[0], st_issued[0]}, 3'b000);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule